// File: doc/BRIEF.md
# Halt and Wake Sequencer

This block takes a small processor core into its low-power halt state and brings it back out. When the core issues a halt strobe while running, the block gates the system oscillator off and raises a hold on execution. It can also pulse a clear to the watchdog counter. It then waits for a wake source. The sources are a watchdog overflow, a fresh interrupt request, or a falling edge on an enabled pin of an 8-bit port. A full external reset is handled by the block's own synchronous reset.

After a wake, the block keeps execution held for a fixed number of clock cycles while the oscillator settles. It then presents, for exactly one cycle, the action the core must take. The three actions are: carry on at the next instruction, take the interrupt vector, or do a warm restart of the program counter and stack pointer. Two status flags tell software why the core came back. The first shows that a halt was entered. The second shows that a watchdog time-out occurred.

Top module: `pwr_halt_ctrl`

## Requirements
- R1: While rst_n is low on a clock edge, the block returns to the running state. After that edge sys_osc_en_o=1, cpu_hold_o=0, resume_valid_o=0, wdt_clr_o=0, pdf_o=0 and to_o=0.
- R2: A halt_i strobe seen while running (cpu_hold_o=0) gives sys_osc_en_o=0, cpu_hold_o=1, pdf_o=1 and to_o=0 from the next cycle on.
- R3: wdt_clr_o is high for exactly the one cycle after an accepted halt, and only when wdt_clk_sel_i=1 at that halt.
- R4: A clrwdt_i strobe clears pdf_o. A wdt_ovf_i pulse sets to_o at any time. to_o is cleared only by reset or by an accepted halt, and an overflow wins if both occur in the same cycle.
- R5: Port pins pass through a two-flop synchroniser. A falling edge on a pin whose bit in port_wake_en_i is 1 wakes the block. A falling edge on a disabled pin, or a rising edge on any pin, leaves it halted.
- R6: An interrupt request bit that was already set when the halt was accepted cannot wake the block. A request bit that rises while halted does wake it, whatever its enable.
- R7: When the block wakes, sys_osc_en_o returns to 1 at once. resume_valid_o pulses for one cycle exactly SETTLE_CYC cycles after the first cycle with the oscillator back on (default 1024). cpu_hold_o drops in the cycle after that pulse.
- R8: resume_act_o during the pulse is encoded as follows. 2 means a warm restart and is given for a watchdog wake. 1 means take the vector and is given for an interrupt wake where a waking request is enabled and stack_full_i=0. 0 means the next instruction and is given for a port wake, or for an interrupt wake that is disabled or meets a full stack. The value 3 never appears.
- R9: When several sources fire in the same cycle, the watchdog wins over interrupts, and interrupts win over the port.
- R10: halt_i has no effect while execution is held (settling or resuming). In particular it does not clear to_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| halt_i | input | 1 | Halt instruction strobe from the core |
| clrwdt_i | input | 1 | Clear-watchdog instruction strobe |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| wdt_clk_sel_i | input | 1 | 1 when the watchdog runs from its own or the RTC oscillator |
| irq_req_i | input | NIRQ | Interrupt request flags |
| irq_en_i | input | NIRQ | Interrupt enables |
| stack_full_i | input | 1 | Call stack has no free entry |
| port_i | input | PORT_W | Raw port pin levels |
| port_wake_en_i | input | PORT_W | Per-pin wake enable |
| sys_osc_en_o | output | 1 | System oscillator enable |
| cpu_hold_o | output | 1 | Execution held |
| wdt_clr_o | output | 1 | One-cycle watchdog clear |
| resume_valid_o | output | 1 | One-cycle resume strobe |
| resume_act_o | output | 2 | Resume action code (see R8) |
| pdf_o | output | 1 | Power-down flag |
| to_o | output | 1 | Watchdog time-out flag |

## Verification
The assertions assume that halt_i, clrwdt_i and wdt_ovf_i are single-cycle strobes. They also assume that the core raises halt_i only while cpu_hold_o is low, except where R10 is tested on purpose. The properties about to_o leave out cycles that carry a watchdog overflow, because an overflow may arrive in any state. The bench drives every input on the falling clock edge and gives each strobe for a single cycle. It lets port levels settle through the synchroniser before each halt, so that no stale edge is mistaken for a wake.

// File: rtl/pwr_halt_pkg.sv
// Shared types for the halt/wake sequencer: controller states and the
// resume action code handed to the core.
package pwr_halt_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALTED = 2'd1,
        ST_SETTLE = 2'd2,
        ST_RESUME = 2'd3
    } halt_state_e;

    typedef enum logic [1:0] {
        ACT_NEXT   = 2'd0,
        ACT_VECTOR = 2'd1,
        ACT_WARM   = 2'd2
    } wake_act_e;

endpackage

// File: rtl/port_wake_detect.sv
// Synchronises the port pins (two flops) and flags a falling edge on any
// pin whose wake enable is set. Assumes the pins are asynchronous to clk.
module port_wake_detect #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_i,
    input  logic [PORT_W-1:0] wake_en_i,
    output logic              wake_o
);
    logic [PORT_W-1:0] sync1_q, sync2_q, prev_q;
    logic [PORT_W-1:0] fall;

    // Two-stage synchroniser plus a history stage; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '1;
            sync2_q <= '1;
            prev_q  <= '1;
        end else begin
            sync1_q <= port_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Per-pin falling-edge detect, masked by the enables.
    for (genvar b = 0; b < PORT_W; b++) begin : g_pin
        assign fall[b] = prev_q[b] & ~sync2_q[b] & wake_en_i[b];
    end

    assign wake_o = |fall;
endmodule

// File: rtl/irq_wake_qual.sv
// Records the request flags at halt entry and reports only requests that
// rose afterwards as wake causes; also decides whether the vector may be
// taken (a waking request enabled and stack not full).
module irq_wake_qual #(
    parameter int NIRQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_i,
    input  logic [NIRQ-1:0] irq_req_i,
    input  logic [NIRQ-1:0] irq_en_i,
    input  logic            stack_full_i,
    output logic            wake_o,
    output logic            vec_ok_o
);
    logic [NIRQ-1:0] stale_q;
    logic [NIRQ-1:0] fresh;

    // Snapshot of requests already pending when the halt was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)         stale_q <= '0;
        else if (capture_i) stale_q <= irq_req_i;
    end

    // Fresh requests and the vector decision.
    always_comb begin
        fresh    = irq_req_i & ~stale_q;
        wake_o   = |fresh;
        vec_ok_o = (|(fresh & irq_en_i)) && !stack_full_i;
    end
endmodule

// File: rtl/settle_timer.sv
// Counts the settling window; done_o is high in the last cycle of a run
// of CYC enabled cycles. Assumes CYC >= 2.
module settle_timer #(
    parameter int CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (CYC > 2) ? $clog2(CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt_q;

    // Counter runs while enabled and restarts from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/halt_fsm.sv
// Controller sequencing RUN -> HALTED -> SETTLE -> RESUME -> RUN and
// latching the resume action at wake time (watchdog > interrupt > port).
module halt_fsm
    import pwr_halt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        halt_i,
    input  logic        wake_wdt_i,
    input  logic        wake_irq_i,
    input  logic        irq_vec_ok_i,
    input  logic        wake_port_i,
    input  logic        settle_done_i,
    output halt_state_e state_o,
    output wake_act_e   act_o
);
    halt_state_e state_q, state_d;
    wake_act_e   act_q, act_d;

    // Next-state and action selection.
    always_comb begin
        state_d = state_q;
        act_d   = act_q;
        unique case (state_q)
            ST_RUN:    if (halt_i) state_d = ST_HALTED;
            ST_HALTED: begin
                if (wake_wdt_i) begin
                    state_d = ST_SETTLE;
                    act_d   = ACT_WARM;
                end else if (wake_irq_i) begin
                    state_d = ST_SETTLE;
                    act_d   = irq_vec_ok_i ? ACT_VECTOR : ACT_NEXT;
                end else if (wake_port_i) begin
                    state_d = ST_SETTLE;
                    act_d   = ACT_NEXT;
                end
            end
            ST_SETTLE: if (settle_done_i) state_d = ST_RESUME;
            ST_RESUME: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // State and action registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            act_q   <= ACT_NEXT;
        end else begin
            state_q <= state_d;
            act_q   <= act_d;
        end
    end

    assign state_o = state_q;
    assign act_o   = act_q;
endmodule

// File: rtl/pwr_halt_ctrl.sv
// Halt/wake sequencer top: gates the system oscillator while halted,
// clears the watchdog on entry, keeps the power-down and time-out flags,
// and hands a one-cycle resume action to the core after settling.
// Assumes halt_i, clrwdt_i and wdt_ovf_i are single-cycle strobes.
module pwr_halt_ctrl
    import pwr_halt_pkg::*;
#(
    parameter int NIRQ       = 4,
    parameter int PORT_W     = 8,
    parameter int SETTLE_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_i,
    input  logic              clrwdt_i,
    input  logic              wdt_ovf_i,
    input  logic              wdt_clk_sel_i,
    input  logic [NIRQ-1:0]   irq_req_i,
    input  logic [NIRQ-1:0]   irq_en_i,
    input  logic              stack_full_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic [PORT_W-1:0] port_wake_en_i,
    output logic              sys_osc_en_o,
    output logic              cpu_hold_o,
    output logic              wdt_clr_o,
    output logic              resume_valid_o,
    output logic [1:0]        resume_act_o,
    output logic              pdf_o,
    output logic              to_o
);
    halt_state_e state;
    wake_act_e   act;
    logic        halt_acc;
    logic        port_wake, irq_wake, irq_vec_ok, settle_done;
    logic        pdf_q, to_q, wdt_clr_q;

    assign halt_acc = (state == ST_RUN) && halt_i;

    port_wake_detect #(.PORT_W(PORT_W)) port_det_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_i   (port_i),
        .wake_en_i(port_wake_en_i),
        .wake_o   (port_wake)
    );

    irq_wake_qual #(.NIRQ(NIRQ)) irq_qual_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_i   (halt_acc),
        .irq_req_i   (irq_req_i),
        .irq_en_i    (irq_en_i),
        .stack_full_i(stack_full_i),
        .wake_o      (irq_wake),
        .vec_ok_o    (irq_vec_ok)
    );

    settle_timer #(.CYC(SETTLE_CYC)) settle_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (state == ST_SETTLE),
        .done_o(settle_done)
    );

    halt_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_i       (halt_i),
        .wake_wdt_i   (wdt_ovf_i),
        .wake_irq_i   (irq_wake),
        .irq_vec_ok_i (irq_vec_ok),
        .wake_port_i  (port_wake),
        .settle_done_i(settle_done),
        .state_o      (state),
        .act_o        (act)
    );

    // Power-down flag: set on halt entry, cleared by the clear-watchdog strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        pdf_q <= 1'b0;
        else if (halt_acc) pdf_q <= 1'b1;
        else if (clrwdt_i) pdf_q <= 1'b0;
    end

    // Time-out flag: set by any overflow, cleared on halt entry.
    always_ff @(posedge clk) begin
        if (!rst_n)         to_q <= 1'b0;
        else if (wdt_ovf_i) to_q <= 1'b1;
        else if (halt_acc)  to_q <= 1'b0;
    end

    // One-cycle watchdog clear after halt entry when the watchdog clock survives.
    always_ff @(posedge clk) begin
        if (!rst_n) wdt_clr_q <= 1'b0;
        else        wdt_clr_q <= halt_acc && wdt_clk_sel_i;
    end

    assign sys_osc_en_o   = (state != ST_HALTED);
    assign cpu_hold_o     = (state != ST_RUN);
    assign resume_valid_o = (state == ST_RESUME);
    assign resume_act_o   = act;
    assign wdt_clr_o      = wdt_clr_q;
    assign pdf_o          = pdf_q;
    assign to_o           = to_q;
endmodule

// File: rtl/pwr_halt_ctrl_chk.sv
// Protocol checker for the halt/wake sequencer, bound to every instance.
// Assumes single-cycle strobes on halt_i and wdt_ovf_i.
module pwr_halt_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_i,
    input logic       wdt_ovf_i,
    input logic       wdt_clk_sel_i,
    input logic       sys_osc_en_o,
    input logic       cpu_hold_o,
    input logic       wdt_clr_o,
    input logic       resume_valid_o,
    input logic [1:0] resume_act_o,
    input logic       pdf_o,
    input logic       to_o
);
    // R2: an accepted halt gates the oscillator and updates the flags
    a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !cpu_hold_o && !wdt_ovf_i) |=> (!sys_osc_en_o && cpu_hold_o && pdf_o && !to_o));

    // R3: the clear follows an accepted halt with a surviving watchdog clock
    a_r3_clr_follows_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !cpu_hold_o && wdt_clk_sel_i) |=> wdt_clr_o);

    a_r3_clr_only_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_o |=> !wdt_clr_o);

    // R4: an overflow always sets the time-out flag
    a_r4_ovf_sets_to: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf_i |=> to_o);

    // R7: oscillator is off only while execution is held
    a_r7_osc_off_held: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_osc_en_o |-> cpu_hold_o);

    // R7: resume strobe lasts one cycle and releases the hold
    a_r7_resume_release: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid_o |=> (!resume_valid_o && !cpu_hold_o));

    // R8: reserved action code never presented
    a_r8_action_legal: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid_o |-> (resume_act_o != 2'd3));

    // R10: while held, only an overflow may move the time-out flag
    a_r10_halt_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hold_o && !wdt_ovf_i) |=> (to_o == $past(to_o)));
endmodule

bind pwr_halt_ctrl pwr_halt_ctrl_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .halt_i        (halt_i),
    .wdt_ovf_i     (wdt_ovf_i),
    .wdt_clk_sel_i (wdt_clk_sel_i),
    .sys_osc_en_o  (sys_osc_en_o),
    .cpu_hold_o    (cpu_hold_o),
    .wdt_clr_o     (wdt_clr_o),
    .resume_valid_o(resume_valid_o),
    .resume_act_o  (resume_act_o),
    .pdf_o         (pdf_o),
    .to_o          (to_o)
);

// File: tb/pwr_halt_ctrl_tb_top.sv
// Scoreboard bench: driver tasks queue the expected resume action, the
// monitor pops it on each resume strobe and also checks the settle length.
module pwr_halt_ctrl_tb_top;
    localparam int NIRQ   = 4;
    localparam int PORT_W = 8;
    localparam int SETTLE = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              halt_i = 1'b0, clrwdt_i = 1'b0, wdt_ovf_i = 1'b0;
    logic              wdt_clk_sel_i = 1'b1, stack_full_i = 1'b0;
    logic [NIRQ-1:0]   irq_req_i = '0, irq_en_i = '0;
    logic [PORT_W-1:0] port_i = '1, port_wake_en_i = '0;
    logic              sys_osc_en_o, cpu_hold_o, wdt_clr_o, resume_valid_o;
    logic [1:0]        resume_act_o;
    logic              pdf_o, to_o;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int settle_cnt = 0;
    logic prev_osc = 1'b1;
    logic chk_release = 1'b0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_halt_ctrl #(.NIRQ(NIRQ), .PORT_W(PORT_W), .SETTLE_CYC(SETTLE)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: settle length, scoreboard pop, hold release.
    always @(negedge clk) begin
        if (chk_release) begin
            chk(!cpu_hold_o, "R7 hold release", int'(cpu_hold_o), 0);
            chk_release = 1'b0;
        end
        if (!prev_osc && sys_osc_en_o) settle_cnt = 0;
        else settle_cnt++;
        prev_osc = sys_osc_en_o;
        if (resume_valid_o && rst_n) begin
            chk(settle_cnt == SETTLE, "R7 settle length", settle_cnt, SETTLE);
            if (exp_q.size() == 0) chk(1'b0, "R8 unexpected resume", int'(resume_act_o), -1);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(resume_act_o) == e, "R8 resume action", int'(resume_act_o), e);
            end
            chk_release = 1'b1;
        end
    end

    // Watchdog on the run length.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Issue a halt and check entry (R2, R3).
    task automatic do_halt(input bit sel);
        @(negedge clk);
        wdt_clk_sel_i = sel;
        halt_i = 1'b1;
        @(negedge clk);
        halt_i = 1'b0;
        chk(!sys_osc_en_o && cpu_hold_o, "R2 osc gated", int'(sys_osc_en_o), 0);
        chk(pdf_o && !to_o, "R2 flags", int'({pdf_o, to_o}), 2);
        chk(wdt_clr_o == sel, "R3 watchdog clear", int'(wdt_clr_o), int'(sel));
        @(negedge clk);
        chk(!wdt_clr_o, "R3 clear one cycle", int'(wdt_clr_o), 0);
    endtask

    task automatic still_halted(input string req);
        idle(20);
        chk(!sys_osc_en_o, req, int'(sys_osc_en_o), 0);
    endtask

    task automatic wait_run();
        for (int i = 0; i < 3000 && cpu_hold_o; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        port_wake_en_i = 8'h0F;
        idle(3);
        // R1: reset state
        chk(sys_osc_en_o && !cpu_hold_o && !resume_valid_o && !wdt_clr_o,
            "R1 reset outputs", int'({sys_osc_en_o, cpu_hold_o}), 2);
        chk(!pdf_o && !to_o, "R1 reset flags", int'({pdf_o, to_o}), 0);
        rst_n = 1'b1;
        idle(2);

        // R5: port wake; bit0 low first so its rise must not wake
        port_i = 8'hFE;
        idle(5);
        exp_q.push_back(0);
        do_halt(1'b1);
        port_i = 8'hFF;
        still_halted("R5 rising edge ignored");
        port_i = 8'hDF;
        still_halted("R5 disabled pin ignored");
        port_i = 8'hDB;
        wait_run();
        port_i = 8'hFF;
        idle(5);

        // R6: stale request cannot wake; fresh enabled one vectors (R8)
        irq_en_i = 4'b0010;
        irq_req_i = 4'b0001;
        exp_q.push_back(1);
        do_halt(1'b0);
        still_halted("R6 stale request ignored");
        irq_req_i = 4'b0011;
        wait_run();
        irq_req_i = '0;
        idle(2);

        // R8: disabled request -> next instruction
        irq_en_i = 4'b0000;
        exp_q.push_back(0);
        do_halt(1'b1);
        irq_req_i = 4'b0100;
        wait_run();
        irq_req_i = '0;
        idle(2);

        // R8: enabled request with a full stack -> next instruction
        irq_en_i = 4'b1111;
        stack_full_i = 1'b1;
        exp_q.push_back(0);
        do_halt(1'b1);
        irq_req_i = 4'b1000;
        wait_run();
        irq_req_i = '0;
        stack_full_i = 1'b0;
        idle(2);

        // R8/R4: watchdog wake -> warm restart, to set, pdf kept
        exp_q.push_back(2);
        do_halt(1'b1);
        wdt_ovf_i = 1'b1;
        @(negedge clk);
        wdt_ovf_i = 1'b0;
        chk(to_o && pdf_o, "R4 watchdog sets TO, PDF kept", int'({pdf_o, to_o}), 3);
        // R10: halt during settle has no effect
        idle(10);
        halt_i = 1'b1;
        @(negedge clk);
        halt_i = 1'b0;
        chk(to_o && sys_osc_en_o, "R10 halt ignored while held", int'({sys_osc_en_o, to_o}), 3);
        wait_run();

        // R4: clear-watchdog strobe clears PDF, TO stays
        clrwdt_i = 1'b1;
        @(negedge clk);
        clrwdt_i = 1'b0;
        chk(!pdf_o && to_o, "R4 clrwdt clears PDF", int'({pdf_o, to_o}), 1);

        // R9: watchdog beats interrupt in the same cycle
        irq_en_i = 4'b1111;
        exp_q.push_back(2);
        do_halt(1'b1);
        irq_req_i = 4'b0001;
        wdt_ovf_i = 1'b1;
        @(negedge clk);
        wdt_ovf_i = 1'b0;
        wait_run();
        irq_req_i = '0;
        idle(2);

        // R9: interrupt beats port in the same cycle
        exp_q.push_back(1);
        do_halt(1'b1);
        irq_req_i = 4'b0010;
        port_i = 8'hFD;
        wait_run();
        irq_req_i = '0;
        port_i = 8'hFF;
        idle(5);

        // R1: reset while halted restores run state and clears flags
        do_halt(1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sys_osc_en_o && !cpu_hold_o && !pdf_o && !to_o, "R1 reset while halted",
            int'({sys_osc_en_o, cpu_hold_o, pdf_o, to_o}), 8);
        rst_n = 1'b1;
        idle(5);

        chk(exp_q.size() == 0, "R8 all resumes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule